// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupts

This block gives software control over a set of general-purpose pins, grouped in banks of up to 32 lines. Each bank has its own set of eight 32-bit registers behind a simple register bus. They control per-line direction, output value and open-drain drive. They also configure per-line interrupt detection: active-low level, active-high level, falling edge, rising edge or both edges. Every bank has a sticky status word and an enable mask. All banks share one interrupt output, which is high while any line has both its status bit and its mask bit set.

The pins enter through a two-flop synchronizer. Edges are found by comparing the synchronized sample against the sample taken one cycle earlier. Detection watches the pad input whether the line is an input or an output. A bank may be built narrower than 32 lines. Its unused upper bits then read as zero, drive nothing and never latch an event.

The register bus is single-cycle. A write takes effect on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`. The byte address splits as follows: bits [4:2] pick the register and the bits above pick the bank, so banks lie 32 bytes apart. Register index order within a bank: 0 open-drain enable, 1 data, 2 direction, 3 edge polarity, 4 any-edge select, 5 mask, 6 level select, 7 status.

Top module: `gpio_multibank`

## Requirements
- R1: After reset, every register reads 0 except direction, which reads the bank's valid-line mask (all lines inputs). `irq_out` and all of `pin_oe` are 0.
- R2: A bank's registers lie at byte address bank*32 + index*4, using the index order given above. A direction bit of 0 makes the line an output: `pin_out` carries the data bit and `pin_oe` is 1. A direction bit of 1 makes the line an input with `pin_oe` 0.
- R3: A read of the data register returns the synchronized pin value for input lines and the written value for output lines.
- R4: On an output line with the open-drain bit set, `pin_out` is 0 and `pin_oe` is 1 only while the data bit is 0.
- R5: With the level bit 0 and the any-edge bit 0, an edge-polarity bit of 1 latches status on a rising pin edge and a 0 latches it on a falling edge. The status bit is set three clock edges after the pin changes.
- R6: With the level bit 0 and the any-edge bit 1, both edges latch status and the edge-polarity bit has no effect.
- R7: With the level bit 1, status latches while the pin equals the edge-polarity bit (1 = active high, 0 = active low). A clear issued while the level is still active leaves the bit set.
- R8: Writing the status register clears exactly the bits written as 1 and leaves the others unchanged.
- R9: When a detected event and a clear of the same status bit fall on the same clock edge, the bit ends up set.
- R10: Status latches whether or not the line is masked. `irq_out` is the OR over all banks of (status AND mask).
- R11: In a bank narrower than 32 lines, the bits at and above its width read as 0 in every register and never set status.
- R12: A read from a bank index at or beyond the number of banks returns 0, and writes to it change no state.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address: bank in upper bits, register in [4:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | NUM_BANKS*32 | Pad inputs, bank b on bits [b*32 +: 32] |
| pin_out | output | NUM_BANKS*32 | Pad output values |
| pin_oe | output | NUM_BANKS*32 | Pad output enables |
| irq_out | output | 1 | Combined interrupt request of all banks |

## Verification
The status flop has two writers: a detected event sets a bit, and a write-one-to-clear on the bus clears it. Both can act on the same clock edge. The bench provokes this on an any-edge line. It first latches status with a rising edge, then lowers the pin and times the clear write so it is captured on the exact edge where the falling event reaches the status flop. The bench counts three edges from the pin change for this. The bench expects the bit still set afterwards, and it repeats the clear with no event present to show that the clear alone does work. The same race is judged for level lines, where a clear under an active level must not drop the bit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned LINES_MAX = 32;
  localparam int unsigned REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    RS_OPEN_DRAIN = 3'd0,
    RS_DATA       = 3'd1,
    RS_DIR        = 3'd2,
    RS_EDGE_POL   = 3'd3,
    RS_ANY_EDGE   = 3'd4,
    RS_MASK       = 3'd5,
    RS_LEVEL      = 3'd6,
    RS_STATUS     = 3'd7
  } regsel_e;

  // Ones in the bit positions a bank of the given width actually has.
  function automatic logic [LINES_MAX-1:0] line_mask(input int unsigned w);
    if (w >= LINES_MAX) return '1;
    return (32'd1 << w) - 32'd1;
  endfunction

  // Per-line trigger decision from the three configuration planes.
  function automatic logic [LINES_MAX-1:0] line_event(
    input logic [LINES_MAX-1:0] lvl,
    input logic [LINES_MAX-1:0] pol,
    input logic [LINES_MAX-1:0] any,
    input logic [LINES_MAX-1:0] cur,
    input logic [LINES_MAX-1:0] prev
  );
    logic [LINES_MAX-1:0] lvl_hit, rise, fall, edge_hit;
    lvl_hit  = (cur & pol) | (~cur & ~pol);
    rise     = cur & ~prev;
    fall     = ~cur & prev;
    edge_hit = (any & (rise | fall)) | (~any & ((pol & rise) | (~pol & fall)));
    return (lvl & lvl_hit) | (~lvl & edge_hit);
  endfunction

  // Value seen on a data-register read: pad for inputs, register for outputs.
  function automatic logic [LINES_MAX-1:0] data_view(
    input logic [LINES_MAX-1:0] dir,
    input logic [LINES_MAX-1:0] pad,
    input logic [LINES_MAX-1:0] dout
  );
    return (dir & pad) | (~dir & dout);
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_bank_unit.sv
module gpio_bank_unit
  import gpio_bank_pkg::*;
#(
  parameter int unsigned LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_IDX_W-1:0] reg_idx,
  input  logic [31:0]          wr_data,
  output logic [31:0]          rd_data,
  input  logic [31:0]          pad_i,
  output logic [31:0]          pad_o,
  output logic [31:0]          pad_oe,
  output logic [31:0]          stat_o,
  output logic [31:0]          mask_o,
  output logic [31:0]          evt_o,
  output logic [31:0]          clr_o,
  output logic [31:0]          od_o
);
  localparam logic [31:0] VMASK = line_mask(LINES);

  logic [31:0] od_q, dout_q, dir_q, pol_q, any_q, mask_q, lvl_q, stat_q;
  logic [31:0] cur, prev, evt, clr, wval;

  gpio_pin_sync #(.WIDTH(32)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pad_i (pad_i & VMASK),
    .cur_o (cur),
    .prev_o(prev)
  );

  assign wval = wr_data & VMASK;
  assign evt  = line_event(lvl_q, pol_q, any_q, cur, prev) & VMASK;
  assign clr  = (wr_en && reg_idx == RS_STATUS) ? wval : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_q   <= '0;
      dout_q <= '0;
      dir_q  <= VMASK;
      pol_q  <= '0;
      any_q  <= '0;
      mask_q <= '0;
      lvl_q  <= '0;
    end else if (wr_en) begin
      case (reg_idx)
        RS_OPEN_DRAIN: od_q   <= wval;
        RS_DATA:       dout_q <= wval;
        RS_DIR:        dir_q  <= wval;
        RS_EDGE_POL:   pol_q  <= wval;
        RS_ANY_EDGE:   any_q  <= wval;
        RS_MASK:       mask_q <= wval;
        RS_LEVEL:      lvl_q  <= wval;
        default:       ;
      endcase
    end
  end

  // Set has priority over a same-edge clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr) | evt;
  end

  always_comb begin
    case (reg_idx)
      RS_OPEN_DRAIN: rd_data = od_q;
      RS_DATA:       rd_data = data_view(dir_q, cur, dout_q) & VMASK;
      RS_DIR:        rd_data = dir_q;
      RS_EDGE_POL:   rd_data = pol_q;
      RS_ANY_EDGE:   rd_data = any_q;
      RS_MASK:       rd_data = mask_q;
      RS_LEVEL:      rd_data = lvl_q;
      default:       rd_data = stat_q;
    endcase
  end

  assign pad_o  = dout_q & ~od_q;
  assign pad_oe = VMASK & ~dir_q & ~(od_q & dout_q);
  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign evt_o  = evt;
  assign clr_o  = clr;
  assign od_o   = od_q;
endmodule

// File: rtl/gpio_irq_reduce.sv
module gpio_irq_reduce #(
  parameter int unsigned NB = 2
) (
  input  logic [NB*32-1:0] stat_i,
  input  logic [NB*32-1:0] mask_i,
  output logic             irq_o
);
  logic [NB-1:0] part;

  for (genvar b = 0; b < NB; b++) begin : g_part
    assign part[b] = |(stat_i[b*32 +: 32] & mask_i[b*32 +: 32]);
  end

  assign irq_o = |part;
endmodule

// File: rtl/gpio_multibank.sv
module gpio_multibank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned        NUM_BANKS = 2,
  parameter int unsigned        ADDR_W    = 8,
  parameter logic [NUM_BANKS*6-1:0] BANK_WIDTHS = {6'd20, 6'd32}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NUM_BANKS*32-1:0] pin_in,
  output logic [NUM_BANKS*32-1:0] pin_out,
  output logic [NUM_BANKS*32-1:0] pin_oe,
  output logic                    irq_out
);
  localparam int unsigned LW     = NUM_BANKS * 32;
  localparam int unsigned BSEL_W = ADDR_W - 5;

  logic [BSEL_W-1:0]    bank_idx;
  logic [REG_IDX_W-1:0] reg_idx;
  logic                 unused_addr_lsb;
  logic [31:0]          rd_bank [NUM_BANKS];

  // Named internal events, observed by the bound checker.
  logic [LW-1:0] evt_vec, stat_vec, mask_vec, clr_vec, od_vec, valid_vec;

  assign bank_idx        = bus_addr[ADDR_W-1:5];
  assign reg_idx         = bus_addr[4:2];
  assign unused_addr_lsb = ^bus_addr[1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned W = int'(BANK_WIDTHS[b*6 +: 6]);
    logic sel;
    assign sel = (bank_idx == BSEL_W'(b));
    assign valid_vec[b*32 +: 32] = line_mask(W);

    gpio_bank_unit #(.LINES(W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_we & sel),
      .reg_idx(reg_idx),
      .wr_data(bus_wdata),
      .rd_data(rd_bank[b]),
      .pad_i  (pin_in[b*32 +: 32]),
      .pad_o  (pin_out[b*32 +: 32]),
      .pad_oe (pin_oe[b*32 +: 32]),
      .stat_o (stat_vec[b*32 +: 32]),
      .mask_o (mask_vec[b*32 +: 32]),
      .evt_o  (evt_vec[b*32 +: 32]),
      .clr_o  (clr_vec[b*32 +: 32]),
      .od_o   (od_vec[b*32 +: 32])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_idx == BSEL_W'(b)) bus_rdata = rd_bank[b];
    end
  end

  gpio_irq_reduce #(.NB(NUM_BANKS)) u_irq (
    .stat_i(stat_vec),
    .mask_i(mask_vec),
    .irq_o (irq_out)
  );
endmodule

// File: rtl/gpio_multibank_sva.sv
module gpio_multibank_sva #(
  parameter int unsigned NB = 2,
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_rdata,
  input logic [NB*32-1:0] pin_out,
  input logic [NB*32-1:0] pin_oe,
  input logic          irq_out,
  input logic [NB*32-1:0] evt_vec,
  input logic [NB*32-1:0] stat_vec,
  input logic [NB*32-1:0] mask_vec,
  input logic [NB*32-1:0] clr_vec,
  input logic [NB*32-1:0] od_vec,
  input logic [NB*32-1:0] valid_vec
);
  p_event_latches_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_vec & $past(evt_vec)) == $past(evt_vec)));

  p_set_needs_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_vec & ~$past(stat_vec) & ~$past(evt_vec)) == '0));

  p_clear_only_written_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~stat_vec & $past(stat_vec) & ~$past(clr_vec)) == '0));

  p_irq_follows_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_vec & mask_vec) != '0) |-> irq_out);

  p_irq_needs_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((stat_vec & mask_vec) != '0));

  p_narrow_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_vec & ~valid_vec) == '0) && ((pin_oe & ~valid_vec) == '0));

  p_open_drain_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((od_vec & pin_oe & pin_out) == '0));

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr[AW-1:5]) >= NB) |-> (bus_rdata == '0));
endmodule

bind gpio_multibank gpio_multibank_sva #(.NB(NUM_BANKS), .AW(ADDR_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .irq_out  (irq_out),
  .evt_vec  (evt_vec),
  .stat_vec (stat_vec),
  .mask_vec (mask_vec),
  .clr_vec  (clr_vec),
  .od_vec   (od_vec),
  .valid_vec(valid_vec)
);

// File: tb/gpio_multibank_test.sv
`timescale 1ns/1ps
module gpio_multibank_test;
  localparam int NB = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] pin_in = '0;
  logic [63:0] pin_out, pin_oe;
  logic        irq_out;

  int checks = 0;
  int failures = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  gpio_multibank #(.NUM_BANKS(NB), .ADDR_W(8), .BANK_WIDTHS({6'd20, 6'd32})) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  // Register index: 0 od, 1 data, 2 dir, 3 pol, 4 any, 5 mask, 6 level, 7 status.
  function automatic logic [7:0] ra(input int bank, input int idx);
    return 8'(bank * 32 + idx * 4);
  endfunction

  // {level, polarity, any-edge, pin before, pin after, expected status}
  localparam logic [5:0] VEC [0:9] = '{
    6'b010_01_1, 6'b010_10_0, 6'b000_10_1, 6'b000_01_0, 6'b001_01_1,
    6'b011_10_1, 6'b110_01_1, 6'b100_10_1, 6'b100_11_0, 6'b001_11_0
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    rd(ra(0, 2), rv); chk("R1 dir bank0", rv, 32'hFFFF_FFFF);
    rd(ra(1, 2), rv); chk("R1 dir bank1", rv, 32'h000F_FFFF);
    rd(ra(0, 7), rv); chk("R1 status", rv, 0);
    rd(ra(0, 5), rv); chk("R1 mask", rv, 0);
    rd(ra(1, 0), rv); chk("R1 open-drain", rv, 0);
    chk("R1 irq", irq_out, 0);
    chk("R1 pin_oe", pin_oe, 0);

    // R12 unmapped bank
    wr(ra(5, 2), 32'h0);
    rd(ra(5, 2), rv); chk("R12 unmapped read", rv, 0);
    rd(ra(1, 2), rv); chk("R12 write ignored", rv, 32'h000F_FFFF);

    // Trigger table on bank0 line 3 (R5 edge, R6 any-edge, R7 level)
    for (int i = 0; i < 10; i++) begin
      logic [5:0] v;
      string tag;
      v = VEC[i];
      tag = v[5] ? "R7" : (v[3] ? "R6" : "R5");
      pin_in[3] = v[2];
      wait_cyc(4);
      wr(ra(0, 6), {28'd0, v[5], 3'd0});
      wr(ra(0, 3), {28'd0, v[4], 3'd0});
      wr(ra(0, 4), {28'd0, v[3], 3'd0});
      wr(ra(0, 5), 32'h8);
      wr(ra(0, 7), 32'hFFFF_FFFF);
      pin_in[3] = v[1];
      wait_cyc(3);
      rd(ra(0, 7), rv);
      chk($sformatf("%s table %0d status", tag, i), rv[3], v[0]);
      chk($sformatf("R10 table %0d irq", i), irq_out, v[0]);
    end
    wr(ra(0, 6), 0); wr(ra(0, 3), 0); wr(ra(0, 4), 0); wr(ra(0, 5), 0);
    pin_in[3] = 1'b0;
    wait_cyc(4);
    wr(ra(0, 7), 32'hFFFF_FFFF);

    // R2 outputs
    wr(ra(0, 2), 32'hFFFF_FF00);
    wr(ra(0, 1), 32'h0000_00A5);
    chk("R2 pin_out", pin_out[7:0], 8'hA5);
    chk("R2 pin_oe", pin_oe[31:0], 32'h0000_00FF);

    // R3 data readback
    pin_in[15:0] = 16'h3CFF;
    wait_cyc(3);
    rd(ra(0, 1), rv); chk("R3 data view", rv, 32'h0000_3CA5);

    // R4 open drain
    wr(ra(0, 0), 32'h0000_000F);
    chk("R4 oe", pin_oe[7:0], 8'hFA);
    chk("R4 out", pin_out[7:0], 8'hA0);
    wr(ra(0, 0), 0);
    wr(ra(0, 2), 32'hFFFF_FFFF);
    pin_in[15:0] = '0;
    wait_cyc(4);
    wr(ra(0, 7), 32'hFFFF_FFFF);

    // R8 write-one-to-clear
    wr(ra(0, 3), 32'h30);
    pin_in[5:4] = 2'b11;
    wait_cyc(3);
    rd(ra(0, 7), rv); chk("R5 rise two lines", rv, 32'h30);
    wr(ra(0, 7), 32'h10);
    rd(ra(0, 7), rv); chk("R8 partial clear", rv, 32'h20);

    // R10 masking
    chk("R10 masked no irq", irq_out, 0);
    wr(ra(0, 5), 32'h20); chk("R10 unmask irq", irq_out, 1);
    wr(ra(0, 5), 0);      chk("R10 remask", irq_out, 0);
    wr(ra(0, 7), 32'hFFFF_FFFF);

    // R10 second bank drives shared output
    wr(ra(1, 3), 32'h4);
    wr(ra(1, 5), 32'h4);
    pin_in[34] = 1'b1;
    wait_cyc(3);
    chk("R10 bank1 irq", irq_out, 1);
    wr(ra(1, 7), 32'h4);
    chk("R10 bank1 cleared", irq_out, 0);

    // R11 narrow bank
    wr(ra(1, 4), 32'hFFFF_FFFF);
    rd(ra(1, 4), rv); chk("R11 any-edge readback", rv, 32'h000F_FFFF);
    wr(ra(1, 5), 32'hFFFF_FFFF);
    rd(ra(1, 5), rv); chk("R11 mask readback", rv, 32'h000F_FFFF);
    pin_in[57] = 1'b1;
    wait_cyc(3);
    rd(ra(1, 7), rv); chk("R11 no status above width", rv, 0);
    chk("R11 no irq", irq_out, 0);
    wr(ra(1, 4), 0); wr(ra(1, 5), 0);

    // R7 level re-set after clear
    wr(ra(0, 6), 32'h200);
    wr(ra(0, 3), 32'h200);
    pin_in[9] = 1'b1;
    wait_cyc(3);
    wr(ra(0, 7), 32'h200);
    rd(ra(0, 7), rv); chk("R7 level survives clear", rv[9], 1'b1);
    pin_in[9] = 1'b0;
    wait_cyc(3);
    wr(ra(0, 7), 32'h200);
    rd(ra(0, 7), rv); chk("R7 inactive clears", rv[9], 1'b0);
    wr(ra(0, 6), 0); wr(ra(0, 3), 0);

    // R9 event on the clear edge
    wr(ra(0, 4), 32'h1000);
    pin_in[12] = 1'b1;
    wait_cyc(3);
    rd(ra(0, 7), rv); chk("R6 rise latched", rv[12], 1'b1);
    @(negedge clk);
    pin_in[12] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = ra(0, 7); bus_wdata = 32'h1000;
    @(negedge clk);
    bus_we = 1'b0;
    rd(ra(0, 7), rv); chk("R9 set wins over clear", rv[12], 1'b1);
    wr(ra(0, 7), 32'h1000);
    rd(ra(0, 7), rv); chk("R9 clear alone", rv[12], 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule